// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs read and write cycles to external memory over one shared 16-bit address/data bus. An internal requester offers a request with an address, write data, a read/write flag and a width select. The block accepts the request only when it is idle. It then drives the address for one clock and moves data for a fixed number of clocks. After that it returns to idle and pulses a completion flag.

The block gives two address strobes for an external latch or decoder. The first is a one-clock active-high latch pulse that marks the start of the cycle. The second is an active-low valid level that covers the whole cycle and releases on the clock after the last data clock. The block also drives active-low read and write enables and a separate tri-state enable for each byte lane. A narrow (8-bit) access uses only the low byte lane. Read data from a narrow access returns with its upper byte cleared.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset, `adv_n`, `rd_n` and `wr_n` are 1, `ale`, `done`, `bus_oe_lo` and `bus_oe_hi` are 0, `req_ready` is 1, and `rd_data` is 0.
- R2: While no request is accepted, the block stays idle: `ale` stays 0 and `adv_n` stays 1.
- R3: On the clock after a request is accepted, the block is in the address phase. This phase lasts exactly one clock, with `ale`=1, both lane enables at 1, and `bus_out` equal to the full 16-bit request address. A latch that loads while `ale` is high then holds that address.
- R4: `adv_n` is 0 for exactly 1+DATA_CYC clocks per access (3 with defaults). It returns to 1 on the clock right after the final data clock.
- R5: `ale` is 0 in every data-phase clock.
- R6: On a write (`req_write`=1), `wr_n` is 0 and `rd_n` is 1 in each data clock, and `bus_out` carries the write data. `bus_oe_lo` stays 1 through both phases.
- R7: On a read, `rd_n` is 0, `wr_n` is 1 and both lane enables are 0 in each data clock. `bus_in` is sampled at the end of the final data clock and appears on `rd_data` from the next clock.
- R8: The width select is `req_wide`: 1 means 16-bit, 0 means 8-bit. On an 8-bit write, `bus_oe_hi` is 0 in the data phase. On an 8-bit read, `rd_data[15:8]` is 0 and `rd_data[7:0]` is `bus_in[7:0]`.
- R9: `done` is a one-clock pulse in the final data clock, and `req_ready` is 0 from the address phase through that clock. A request held high during a cycle is not accepted until the block is idle again. So back-to-back accesses are separated by one idle clock with `adv_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle; a request is accepted this clock |
| done | output | 1 | Final data clock of an access |
| rd_data | output | 16 | Captured read data |
| bus_out | output | 16 | Value driven onto the shared bus |
| bus_in | input | 16 | Value sensed on the shared bus |
| bus_oe_lo | output | 1 | Tri-state enable, low byte lane |
| bus_oe_hi | output | 1 | Tri-state enable, high byte lane |
| ale | output | 1 | Address latch pulse, active high |
| adv_n | output | 1 | Address valid, active low |
| rd_n | output | 1 | Read enable, active low |
| wr_n | output | 1 | Write enable, active low |

## Verification
Two events can fall in the same clock: the completion pulse of one access, and a waiting request for the next access. The bench provokes this by holding `req_valid` high from one access straight into the next. It checks that the first access still shows exactly three clocks of `adv_n` low. It then checks for one idle clock with `adv_n` high and `req_ready` set, and that the next address phase starts on the following clock with the new address.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int BUS_W    = 16,
  parameter int DATA_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_wide,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [BUS_W-1:0] rd_data,
  output logic [BUS_W-1:0] bus_out,
  input  logic [BUS_W-1:0] bus_in,
  output logic             bus_oe_lo,
  output logic             bus_oe_hi,
  output logic             ale,
  output logic             adv_n,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int HALF = BUS_W / 2;
  localparam int CW   = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [BUS_W-1:0] a_q, d_q;
  logic            wr_q, wide_q;
  logic            in_data, last;

  assign in_data = (st == S_DATA);
  assign last    = in_data && (cnt == CW'(DATA_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      a_q     <= '0;
      d_q     <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_q    <= req_addr;
          d_q    <= req_wdata;
          wr_q   <= req_write;
          wide_q <= req_wide;
          st     <= S_ADDR;
        end
        S_ADDR: begin
          cnt <= '0;
          st  <= S_DATA;
        end
        S_DATA: if (last) begin
          st <= S_IDLE;
          if (!wr_q)
            rd_data <= wide_q ? bus_in : {{HALF{1'b0}}, bus_in[HALF-1:0]};
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign ale       = (st == S_ADDR);
  assign adv_n     = (st == S_IDLE);
  assign done      = last;
  assign wr_n      = !(in_data && wr_q);
  assign rd_n      = !(in_data && !wr_q);
  assign bus_oe_lo = ale || (in_data && wr_q);
  assign bus_oe_hi = ale || (in_data && wr_q && wide_q);
  assign bus_out   = ale ? a_q : (wide_q ? d_q : {{HALF{1'b0}}, d_q[HALF-1:0]});

  // R3: latch pulse lasts one clock
  a_r3_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);
  // R2: idle keeps both strobes inactive
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (adv_n && !ale));
  // R4: address valid covers the latch pulse and releases after done
  a_r4_adv_cover: assert property (@(posedge clk) disable iff (!rst_n) ale |-> !adv_n);
  a_r4_adv_release: assert property (@(posedge clk) disable iff (!rst_n) done |=> adv_n);
  // R5: latch pulse only at cycle start
  a_r5_ale_then_data: assert property (@(posedge clk) disable iff (!rst_n) ale |=> (!adv_n && !ale));
  // R6/R7: enables never both active
  a_r6_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R7: bus released while reading
  a_r7_read_hiz: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> (!bus_oe_lo && !bus_oe_hi));
  // R9: done is a single pulse and a busy block accepts nothing
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && req_ready));
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n) (!req_ready && !done) |=> !req_ready);
endmodule

// File: tb/mux_bus_ctrl_bench.sv
module mux_bus_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, bus_in = '0;
  logic req_ready, done, bus_oe_lo, bus_oe_hi, ale, adv_n, rd_n, wr_n;
  logic [15:0] rd_data, bus_out;

  int n_run = 0, n_fail = 0;
  int adv_cnt = 0;
  logic [15:0] lat_addr = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mux_bus_ctrl u_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data), .bus_out(bus_out),
    .bus_in(bus_in), .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi), .ale(ale),
    .adv_n(adv_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  always @(posedge clk) begin
    if (ale) lat_addr <= bus_out;
    if (!adv_n) adv_cnt <= adv_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit wide, input logic [15:0] a,
                        input logic [15:0] wd, input logic [15:0] rv, input bit keep);
    logic [15:0] lo_mask;
    lo_mask = wide ? 16'hFFFF : 16'h00FF;
    @(negedge clk);
    adv_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
    bus_in = ~rv;
    @(negedge clk);
    check(ale == 1'b1, "R3 ale in address phase", 32'(ale), 32'd1);
    check(bus_out == a, "R3 address on bus", 32'(bus_out), 32'(a));
    check(bus_oe_lo && bus_oe_hi, "R3 both lanes driven", {30'd0, bus_oe_hi, bus_oe_lo}, 32'd3);
    check(!req_ready, "R9 busy in address phase", 32'(req_ready), 32'd0);
    if (!keep) req_valid = 1'b0;
    req_addr = ~a;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(!ale && !adv_n, "R5 data phase strobes", {30'd0, ale, adv_n}, 32'd0);
      check(done == (k == 1), "R9 done on final data clock", 32'(done), 32'(k == 1));
      if (wr) begin
        check(!wr_n && rd_n, "R6 write enables", {30'd0, wr_n, rd_n}, 32'd1);
        check(bus_oe_lo, "R6 low lane driven", 32'(bus_oe_lo), 32'd1);
        check((bus_out & lo_mask) == (wd & lo_mask), "R6 write data", 32'(bus_out & lo_mask), 32'(wd & lo_mask));
        check(bus_oe_hi == wide, "R8 high lane enable", 32'(bus_oe_hi), 32'(wide));
      end else begin
        check(!rd_n && wr_n, "R7 read enables", {30'd0, wr_n, rd_n}, 32'd2);
        check(!bus_oe_lo && !bus_oe_hi, "R7 bus released", {30'd0, bus_oe_hi, bus_oe_lo}, 32'd0);
        bus_in = rv;
      end
    end
    check(lat_addr == a, "R3 external latch holds address", 32'(lat_addr), 32'(a));
    @(negedge clk);
    check(adv_n && !done && req_ready, "R4 release after cycle", {29'd0, adv_n, done, req_ready}, 32'd5);
    check(adv_cnt == 3, "R4 adv_n low length", 32'(adv_cnt), 32'd3);
    if (!wr)
      check(rd_data == (rv & lo_mask), "R7 R8 read data", 32'(rd_data), 32'(rv & lo_mask));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(adv_n && rd_n && wr_n && !ale && !done && !bus_oe_lo && !bus_oe_hi && req_ready && rd_data == 0,
          "R1 reset state", {16'd0, rd_data}, 32'd0);
  endtask

  task automatic t_idle();
    bit bad = 0;
    req_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (ale || !adv_n || !req_ready) bad = 1;
    end
    check(!bad, "R2 idle strobes inactive", 32'(bad), 32'd0);
  endtask

  task automatic t_back_to_back();
    access(1'b1, 1'b1, 16'h1357, 16'h2468, 16'h0, 1'b1);
    req_addr = 16'h8001; req_write = 1'b0; req_wide = 1'b1;
    @(negedge clk);
    check(ale && bus_out == 16'h8001, "R9 next access after one idle clock", 32'(bus_out), 32'h8001);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready && adv_n, "R9 settles idle", {30'd0, req_ready, adv_n}, 32'd3);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    access(1'b1, 1'b1, 16'hA5C3, 16'hBEEF, 16'h0000, 1'b0);
    access(1'b1, 1'b0, 16'h00FF, 16'h12AB, 16'h0000, 1'b0);
    access(1'b0, 1'b1, 16'hFF00, 16'h0000, 16'hCAFE, 1'b0);
    access(1'b0, 1'b0, 16'h7E81, 16'h0000, 16'h9A3C, 1'b0);
    t_back_to_back();
    t_idle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule